// File: doc/BRIEF.md
# BCD Real-Time Clock with Alarm

This block keeps calendar time (seconds, minutes, hours, day of month, month and two-digit year) in packed BCD counters. A one-second pulse is derived by counting single-cycle `osc_tick` strobes, which come from a 32.768 kHz source already brought into the system clock domain. A signed calibration field stretches or shortens the number of strobes in each second. The block answers in a 16-byte register window at the very top of an `ADDR_W`-bit byte address space. Time fields, alarm fields, a control byte and a calibration byte all live in that window.

Software accesses the window with `bus_en` held high for one or more cycles, which forms an access window. Time reads return a snapshot taken before the access window opened, so a rollover during a burst of reads is never seen half-applied. Time writes go into a pending copy. When the access window closes, the pending copy is moved into the counters and also latched as the base time.

Each of four alarm fields carries a mask bit. The alarm flag sets on the second in which every unmasked field equals the new time. The oscillator monitor sets a fail flag when the running oscillator produces no strobe within `FAIL_CYCLES` clocks. On that event the time falls back to the base time, while the control and calibration settings are kept.

Top module: `rtc_bcd_clock`

## Requirements
- R1: After reset the time reads 00:00:00 on day 01, month 01, year 00. The control byte, the calibration byte and all four alarm bytes read 0x00.
- R2: A register is addressed only when `bus_addr[ADDR_W-1:4]` is all ones. The low four bits select the register: 0 seconds, 1 minutes, 2 hours, 3 day, 4 month, 5 year, 6–9 alarm seconds/minutes/hours/day, 10 control, 11 calibration. Offsets 12–15 and every address outside the window read 0x00, and writes to them change nothing.
- R3: Time counts in BCD with one second per calibrated period of strobes. Seconds and minutes roll from 59 to 00, hours count 00–23, and each BCD units digit carries from 9 into the tens digit.
- R4: Day rollover follows month length: 30 days for months 04, 06, 09 and 11, 31 days for the other months, and 29 days for February in a year divisible by 4 (28 otherwise). Month 12 rolls to 01, and year 99 rolls to 00.
- R5: While `bus_en` stays high on a window address, time registers read the snapshot taken before the access window opened. Rollovers during the access window show only after it closes.
- R6: Time writes update a pending copy. The close of the access window loads the pending copy into the counters and into the base time, and restarts the strobe count for the current second. Fields not written keep their previous values.
- R7: Control bit 7 set to 1 halts counting; set to 0, counting runs.
- R8: Calibration bit 5 is the sign and bits 4:0 are the magnitude m. A second lasts TICKS_PER_SEC−m strobes when the sign is 1 (never fewer than 1), and TICKS_PER_SEC+m strobes when the sign is 0.
- R9: In each alarm byte, bit 7 = 1 drops the field from the match and bit 7 = 0 compares bits 6:0. Control bit 1 (and `alarm_flag`) sets on the second tick whose new time matches all unmasked fields.
- R10: While running, if no strobe arrives for `FAIL_CYCLES` consecutive clocks, control bit 0 (and `osc_fail`) sets and the time reverts to the base time. Control bit 7 and the calibration byte are left as they were.
- R11: Writing 0 to control bit 0 or bit 1 clears that flag, and writing 1 to either bit leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| osc_tick | input | 1 | One-cycle strobe per 32.768 kHz oscillator period |
| bus_en | input | 1 | Access strobe; held high across an access window |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from the registers) |
| alarm_flag | output | 1 | Alarm flag (control bit 1) |
| osc_fail | output | 1 | Oscillator-fail flag (control bit 0) |

## Verification
On every cycle, assertions check that read data stays frozen during a held read access window. They also check that a stopped oscillator leaves the time untouched, that a fail event leaves the counters equal to the base time, that the alarm flag rises only on a second tick, and that every uncontested second tick changes the time. Month lengths, leap years, the year wrap, calibrated period lengths, partial writes, mask handling and flag clearing depend on concrete values. The bench's scenarios show these by comparing register reads against expected values that it computes itself.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [7:0] yr;
    logic [4:0] mon;
    logic [5:0] day;
    logic [5:0] hr;
    logic [6:0] min;
    logic [6:0] sec;
  } rtc_time_t;

  localparam rtc_time_t RTC_RESET_TIME = '{yr: 8'h00, mon: 5'h01, day: 6'h01,
                                           hr: 6'h00, min: 7'h00, sec: 7'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  function automatic logic is_leap(input logic [7:0] yr);
    logic r;
    if (!yr[4]) r = (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    else        r = (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    return r;
  endfunction

  function automatic logic [5:0] last_day(input logic [4:0] mon, input logic [7:0] yr);
    logic [5:0] r;
    case (mon)
      5'h02:                      r = is_leap(yr) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: r = 6'h30;
      default:                    r = 6'h31;
    endcase
    return r;
  endfunction

  function automatic rtc_time_t rtc_next(input rtc_time_t t);
    rtc_time_t n;
    logic [7:0] tmp;
    n = t;
    if (t.sec == 7'h59) begin
      n.sec = 7'h00;
      if (t.min == 7'h59) begin
        n.min = 7'h00;
        if (t.hr == 6'h23) begin
          n.hr = 6'h00;
          if (t.day == last_day(t.mon, t.yr)) begin
            n.day = 6'h01;
            if (t.mon == 5'h12) begin
              n.mon = 5'h01;
              if (t.yr == 8'h99) n.yr = 8'h00;
              else               n.yr = bcd_inc(t.yr);
            end else begin
              tmp   = bcd_inc({3'b000, t.mon});
              n.mon = tmp[4:0];
            end
          end else begin
            tmp   = bcd_inc({2'b00, t.day});
            n.day = tmp[5:0];
          end
        end else begin
          tmp  = bcd_inc({2'b00, t.hr});
          n.hr = tmp[5:0];
        end
      end else begin
        tmp   = bcd_inc({1'b0, t.min});
        n.min = tmp[6:0];
      end
    end else begin
      tmp   = bcd_inc({1'b0, t.sec});
      n.sec = tmp[6:0];
    end
    return n;
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rst_sn,
  input  logic       osc_tick,
  input  logic       run,
  input  logic       clear,
  input  logic       cal_sign,
  input  logic [4:0] cal_mag,
  output logic       sec_pulse
);
  localparam int CNT_W = $clog2(TICKS_PER_SEC + 32) + 1;
  localparam logic [CNT_W-1:0] NOMINAL = CNT_W'(TICKS_PER_SEC);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] mag_ext;
  logic             step;

  assign mag_ext = {{(CNT_W-5){1'b0}}, cal_mag};

  always_comb begin
    if (cal_sign) period = (mag_ext >= NOMINAL) ? CNT_W'(1) : NOMINAL - mag_ext;
    else          period = NOMINAL + mag_ext;
  end

  assign step      = osc_tick & run;
  assign sec_pulse = step & (cnt_q >= period - CNT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (clear)          cnt_d = '0;
    else if (sec_pulse) cnt_d = '0;
    else if (step)      cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rtc_osc_monitor.sv
module rtc_osc_monitor #(
  parameter int FAIL_CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_sn,
  input  logic osc_tick,
  input  logic run,
  output logic fail_pulse
);
  localparam int CNT_W = $clog2(FAIL_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(FAIL_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign fail_pulse = run & ~osc_tick & (cnt_q == LIMIT);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || osc_tick) cnt_d = '0;
    else if (fail_pulse)  cnt_d = '0;
    else                  cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_sn,
  input  logic      sec_pulse,
  input  logic      load,
  input  rtc_time_t load_val,
  input  logic      revert,
  output rtc_time_t cur,
  output rtc_time_t nxt,
  output rtc_time_t base
);
  rtc_time_t cur_d, base_d;

  assign nxt = rtc_next(cur);

  always_comb begin
    cur_d  = cur;
    base_d = base;
    if (load) begin
      cur_d  = load_val;
      base_d = load_val;
    end else if (revert) begin
      cur_d = base;
    end else if (sec_pulse) begin
      cur_d = nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      cur  <= RTC_RESET_TIME;
      base <= RTC_RESET_TIME;
    end else begin
      cur  <= cur_d;
      base <= base_d;
    end
  end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_pkg::*;
#(
  parameter int N_FIELDS = 4
) (
  input  logic [N_FIELDS-1:0][7:0] alarm_regs,
  input  rtc_time_t                t,
  output logic                     hit
);
  logic [N_FIELDS-1:0][6:0] fval;
  logic [N_FIELDS-1:0]      fmatch;

  always_comb begin
    fval    = '0;
    fval[0] = t.sec;
    fval[1] = t.min;
    fval[2] = {1'b0, t.hr};
    fval[3] = {1'b0, t.day};
  end

  for (genvar g = 0; g < N_FIELDS; g++) begin : g_field
    assign fmatch[g] = alarm_regs[g][7] | (alarm_regs[g][6:0] == fval[g]);
  end

  assign hit = &fmatch;
endmodule

// File: rtl/rtc_bcd_clock.sv
module rtc_bcd_clock
  import rtc_pkg::*;
#(
  parameter int ADDR_W        = 20,
  parameter int TICKS_PER_SEC = 32768,
  parameter int FAIL_CYCLES   = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              alarm_flag,
  output logic              osc_fail
);
  localparam int N_ALARM = 4;
  localparam int UPPER_W = ADDR_W - 4;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sn = rst_q[1];

  // window decode
  logic       win_hit, acc, wr_hit, commit;
  logic [3:0] off;
  assign win_hit = &bus_addr[ADDR_W-1:4];
  assign off     = bus_addr[3:0];
  assign acc     = bus_en & win_hit;
  assign wr_hit  = acc & bus_wr;

  // state
  logic                     acc_q;
  logic [N_ALARM-1:0][7:0]  alarm_q, alarm_d;
  logic                     stop_q, stop_d;
  logic                     aflag_q, aflag_d;
  logic                     fflag_q, fflag_d;
  logic [5:0]               cal_q, cal_d;
  rtc_time_t                snap_q, snap_d;
  rtc_time_t                pend_q, pend_d;
  logic                     dirty_q, dirty_d;

  rtc_time_t live, live_nxt, base;
  logic      sec_pulse, fail_pulse, alarm_match, alarm_set;

  assign commit = acc_q & ~acc & dirty_q;

  rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
    .clk       (clk),
    .rst_sn    (rst_sn),
    .osc_tick  (osc_tick),
    .run       (~stop_q),
    .clear     (commit),
    .cal_sign  (cal_q[5]),
    .cal_mag   (cal_q[4:0]),
    .sec_pulse (sec_pulse)
  );

  rtc_osc_monitor #(.FAIL_CYCLES(FAIL_CYCLES)) u_mon (
    .clk        (clk),
    .rst_sn     (rst_sn),
    .osc_tick   (osc_tick),
    .run        (~stop_q),
    .fail_pulse (fail_pulse)
  );

  rtc_calendar u_cal (
    .clk       (clk),
    .rst_sn    (rst_sn),
    .sec_pulse (sec_pulse),
    .load      (commit),
    .load_val  (pend_q),
    .revert    (fail_pulse),
    .cur       (live),
    .nxt       (live_nxt),
    .base      (base)
  );

  rtc_alarm_match #(.N_FIELDS(N_ALARM)) u_alarm (
    .alarm_regs (alarm_q),
    .t          (live_nxt),
    .hit        (alarm_match)
  );

  assign alarm_set = sec_pulse & ~commit & alarm_match;

  // next state
  always_comb begin
    snap_d  = acc ? snap_q : live;
    pend_d  = pend_q;
    dirty_d = dirty_q;
    alarm_d = alarm_q;
    stop_d  = stop_q;
    aflag_d = aflag_q;
    fflag_d = fflag_q;
    cal_d   = cal_q;

    if (!acc) begin
      pend_d  = live;
      dirty_d = 1'b0;
    end

    if (wr_hit) begin
      case (off)
        4'd0:  begin pend_d.sec = bus_wdata[6:0]; dirty_d = 1'b1; end
        4'd1:  begin pend_d.min = bus_wdata[6:0]; dirty_d = 1'b1; end
        4'd2:  begin pend_d.hr  = bus_wdata[5:0]; dirty_d = 1'b1; end
        4'd3:  begin pend_d.day = bus_wdata[5:0]; dirty_d = 1'b1; end
        4'd4:  begin pend_d.mon = bus_wdata[4:0]; dirty_d = 1'b1; end
        4'd5:  begin pend_d.yr  = bus_wdata;      dirty_d = 1'b1; end
        4'd6:  alarm_d[0] = bus_wdata;
        4'd7:  alarm_d[1] = bus_wdata;
        4'd8:  alarm_d[2] = bus_wdata;
        4'd9:  alarm_d[3] = bus_wdata;
        4'd10: begin
          stop_d = bus_wdata[7];
          if (!bus_wdata[1]) aflag_d = 1'b0;
          if (!bus_wdata[0]) fflag_d = 1'b0;
        end
        4'd11: cal_d = bus_wdata[5:0];
        default: ;
      endcase
    end

    if (alarm_set)  aflag_d = 1'b1;
    if (fail_pulse) fflag_d = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      acc_q   <= 1'b0;
      alarm_q <= '0;
      stop_q  <= 1'b0;
      aflag_q <= 1'b0;
      fflag_q <= 1'b0;
      cal_q   <= '0;
      snap_q  <= RTC_RESET_TIME;
      pend_q  <= RTC_RESET_TIME;
      dirty_q <= 1'b0;
    end else begin
      acc_q   <= acc;
      alarm_q <= alarm_d;
      stop_q  <= stop_d;
      aflag_q <= aflag_d;
      fflag_q <= fflag_d;
      cal_q   <= cal_d;
      snap_q  <= snap_d;
      pend_q  <= pend_d;
      dirty_q <= dirty_d;
    end
  end

  // read path
  always_comb begin
    bus_rdata = 8'h00;
    if (acc) begin
      case (off)
        4'd0:  bus_rdata = {1'b0, snap_q.sec};
        4'd1:  bus_rdata = {1'b0, snap_q.min};
        4'd2:  bus_rdata = {2'b00, snap_q.hr};
        4'd3:  bus_rdata = {2'b00, snap_q.day};
        4'd4:  bus_rdata = {3'b000, snap_q.mon};
        4'd5:  bus_rdata = snap_q.yr;
        4'd6:  bus_rdata = alarm_q[0];
        4'd7:  bus_rdata = alarm_q[1];
        4'd8:  bus_rdata = alarm_q[2];
        4'd9:  bus_rdata = alarm_q[3];
        4'd10: bus_rdata = {stop_q, 5'b00000, aflag_q, fflag_q};
        4'd11: bus_rdata = {2'b00, cal_q};
        default: bus_rdata = 8'h00;
      endcase
    end
  end

  assign alarm_flag = aflag_q;
  assign osc_fail   = fflag_q;

  logic unused_upper;
  assign unused_upper = ^UPPER_W;
endmodule

// File: rtl/rtc_bcd_clock_chk.sv
module rtc_bcd_clock_chk
  import rtc_pkg::*;
(
  input logic       clk,
  input logic       rst_sn,
  input logic       acc,
  input logic       bus_wr,
  input logic [3:0] off,
  input logic [7:0] bus_rdata,
  input logic       sec_pulse,
  input logic       fail_pulse,
  input logic       commit,
  input logic       stop,
  input logic       aflag,
  input logic       fflag,
  input rtc_time_t  live,
  input rtc_time_t  base
);
  // R5: a held read on a time offset returns unchanging data
  assert_snapshot_hold_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    (acc && $past(acc) && !bus_wr && !$past(bus_wr) && off == $past(off) && off < 4'd6)
      |-> $stable(bus_rdata));

  // R7: a stopped oscillator leaves the time unchanged unless software loads it
  assert_stop_holds_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    (stop && !commit) |=> $stable(live));

  // R10: after a fail event the counters hold the base time
  assert_fail_reverts_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    (fail_pulse && !commit) |=> (live == base));

  // R10: the fail flag never rises while the oscillator is stopped
  assert_fail_only_running_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(fflag) |-> !$past(stop));

  // R9: the alarm flag rises only on a second tick
  assert_alarm_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(aflag) |-> $past(sec_pulse));

  // R3: an uncontested second tick always changes the time
  assert_tick_advances_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    (sec_pulse && !commit && !fail_pulse) |=> (live != $past(live)));
endmodule

bind rtc_bcd_clock rtc_bcd_clock_chk u_chk (
  .clk        (clk),
  .rst_sn     (rst_sn),
  .acc        (acc),
  .bus_wr     (bus_wr),
  .off        (bus_addr[3:0]),
  .bus_rdata  (bus_rdata),
  .sec_pulse  (sec_pulse),
  .fail_pulse (fail_pulse),
  .commit     (commit),
  .stop       (stop_q),
  .aflag      (aflag_q),
  .fflag      (fflag_q),
  .live       (live),
  .base       (base)
);

// File: tb/tb_rtc_bcd_clock.sv
`timescale 1ns/1ps
module tb_rtc_bcd_clock;
  localparam int AW    = 20;
  localparam int TPS   = 40;
  localparam int FAILC = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          osc_tick = 1'b0;
  logic          bus_en = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic          alarm_flag, osc_fail;

  int n_tests = 0;
  int n_fail  = 0;
  logic mon_req = 1'b0;
  logic [7:0] q_exp[$];
  string      q_tag[$];

  always #10 clk = ~clk;

  rtc_bcd_clock #(.ADDR_W(AW), .TICKS_PER_SEC(TPS), .FAIL_CYCLES(FAILC)) dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .alarm_flag(alarm_flag), .osc_fail(osc_fail)
  );

  function automatic logic [AW-1:0] wa(input logic [3:0] o);
    return {{(AW-4){1'b1}}, o};
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items as the design presents read data
  always @(negedge clk) begin
    if (mon_req && q_exp.size() > 0) begin
      logic [7:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      chk(bus_rdata, e, t);
    end
  end

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
    @(posedge clk); #1;
    bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
    q_exp.push_back(exp); q_tag.push_back(tag); mon_req = 1'b1;
    @(posedge clk); #1;
    bus_en = 1'b0; mon_req = 1'b0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_en = 1'b0; bus_wr = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  task automatic set_time(input logic [7:0] y, input logic [7:0] mo, input logic [7:0] d,
                          input logic [7:0] h, input logic [7:0] mi, input logic [7:0] s);
    logic [7:0] v[6];
    v[0] = s; v[1] = mi; v[2] = h; v[3] = d; v[4] = mo; v[5] = y;
    @(posedge clk); #1;
    bus_en = 1'b1; bus_wr = 1'b1;
    for (int i = 0; i < 6; i++) begin
      bus_addr = wa(4'(i)); bus_wdata = v[i];
      @(posedge clk); #1;
    end
    bus_en = 1'b0; bus_wr = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 osc_tick = 1'b1;
    end
    @(posedge clk); #1 osc_tick = 1'b0;
  endtask

  task automatic run_secs_ticks(input int n);
    wr(wa(4'd10), 8'h03);
    run_ticks(n);
    wr(wa(4'd10), 8'h83);
  endtask

  task automatic chk_pin(input logic act, input logic exp, input string tag);
    @(negedge clk);
    chk({7'd0, act}, {7'd0, exp}, tag);
  endtask

  task automatic rd_date(input logic [7:0] d, input logic [7:0] mo, input string tag);
    rd(wa(4'd3), d, tag);
    rd(wa(4'd4), mo, tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset state (control read before the fail monitor can expire)
    rd(wa(4'd10), 8'h00, "R1 ctrl");
    wr(wa(4'd10), 8'h83);                         // stop; flag bits written 1
    rd(wa(4'd10), 8'h80, "R11 writing 1 leaves flags clear");
    rd(wa(4'd0), 8'h00, "R1 sec");
    rd(wa(4'd1), 8'h00, "R1 min");
    rd(wa(4'd2), 8'h00, "R1 hr");
    rd_date(8'h01, 8'h01, "R1 date");
    rd(wa(4'd5), 8'h00, "R1 yr");
    rd(wa(4'd11), 8'h00, "R1 cal");
    rd(wa(4'd6), 8'h00, "R1 alarm sec");
    rd(wa(4'd9), 8'h00, "R1 alarm day");

    // R2 window decode
    rd(wa(4'd13), 8'h00, "R2 unused offset");
    wr({AW{1'b0}}, 8'h45);
    rd({AW{1'b0}}, 8'h00, "R2 outside read");
    rd(wa(4'd0), 8'h00, "R2 outside write ignored");

    // R7 stopped oscillator does not count
    run_ticks(2 * TPS);
    rd(wa(4'd0), 8'h00, "R7 stopped");

    // R6 + R4 year wrap
    set_time(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h58);
    rd(wa(4'd0), 8'h58, "R6 commit sec");
    run_secs_ticks(2 * TPS);
    rd(wa(4'd0), 8'h00, "R3 sec wrap");
    rd(wa(4'd1), 8'h00, "R3 min wrap");
    rd(wa(4'd2), 8'h00, "R3 hr wrap");
    rd_date(8'h01, 8'h01, "R4 new year");
    rd(wa(4'd5), 8'h00, "R4 year 99 to 00");

    // R4 month lengths and leap years
    set_time(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    run_secs_ticks(TPS);
    rd_date(8'h29, 8'h02, "R4 leap feb 29");
    set_time(8'h24, 8'h02, 8'h29, 8'h23, 8'h59, 8'h59);
    run_secs_ticks(TPS);
    rd_date(8'h01, 8'h03, "R4 leap feb end");
    set_time(8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    run_secs_ticks(TPS);
    rd_date(8'h01, 8'h03, "R4 common feb end");
    set_time(8'h23, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59);
    run_secs_ticks(TPS);
    rd_date(8'h01, 8'h05, "R4 30 day month");
    set_time(8'h23, 8'h01, 8'h31, 8'h23, 8'h59, 8'h59);
    run_secs_ticks(TPS);
    rd_date(8'h01, 8'h02, "R4 31 day month");

    // R3 BCD digit carry
    set_time(8'h23, 8'h05, 8'h10, 8'h09, 8'h59, 8'h59);
    run_secs_ticks(TPS);
    rd(wa(4'd2), 8'h10, "R3 hour digit carry");
    rd(wa(4'd1), 8'h00, "R3 minute wrap");
    rd(wa(4'd3), 8'h10, "R3 day unchanged");

    // R6 partial write keeps other fields
    wr(wa(4'd1), 8'h42);
    rd(wa(4'd1), 8'h42, "R6 written min");
    rd(wa(4'd2), 8'h10, "R6 hour kept");
    rd(wa(4'd5), 8'h23, "R6 year kept");

    // R5 snapshot frozen across a rollover in a held read
    set_time(8'h23, 8'h05, 8'h10, 8'h00, 8'h00, 8'h10);
    wr(wa(4'd10), 8'h03);
    @(posedge clk); #1;
    bus_en = 1'b1; bus_wr = 1'b0; bus_addr = wa(4'd0);
    for (int i = 0; i < TPS + 2; i++) begin
      osc_tick = (i < TPS);
      q_exp.push_back(8'h10); q_tag.push_back("R5 held read");
      mon_req = 1'b1;
      @(posedge clk); #1;
    end
    bus_en = 1'b0; mon_req = 1'b0; osc_tick = 1'b0;
    wr(wa(4'd10), 8'h83);
    rd(wa(4'd0), 8'h11, "R5 after window");

    // R8 calibration
    set_time(8'h23, 8'h05, 8'h10, 8'h00, 8'h00, 8'h00);
    wr(wa(4'd11), 8'h25);
    run_secs_ticks(TPS - 6);
    rd(wa(4'd0), 8'h00, "R8 short period not yet");
    run_secs_ticks(1);
    rd(wa(4'd0), 8'h01, "R8 short period done");
    wr(wa(4'd11), 8'h05);
    run_secs_ticks(TPS + 4);
    rd(wa(4'd0), 8'h01, "R8 long period not yet");
    run_secs_ticks(1);
    rd(wa(4'd0), 8'h02, "R8 long period done");
    rd(wa(4'd11), 8'h05, "R8 cal readback");

    // R9 alarm with masks
    wr(wa(4'd11), 8'h00);
    wr(wa(4'd6), 8'h05);
    wr(wa(4'd7), 8'h80);
    wr(wa(4'd8), 8'h80);
    wr(wa(4'd9), 8'h80);
    set_time(8'h23, 8'h05, 8'h10, 8'h00, 8'h00, 8'h04);
    run_secs_ticks(TPS);
    rd(wa(4'd10), 8'h82, "R9 alarm match");
    chk_pin(alarm_flag, 1'b1, "R9 alarm_flag pin");
    wr(wa(4'd10), 8'h81);
    rd(wa(4'd10), 8'h80, "R11 alarm cleared by 0");
    chk_pin(alarm_flag, 1'b0, "R11 alarm_flag pin clear");
    wr(wa(4'd7), 8'h07);
    set_time(8'h23, 8'h05, 8'h10, 8'h00, 8'h00, 8'h04);
    run_secs_ticks(TPS);
    rd(wa(4'd10), 8'h80, "R9 unmasked minute mismatch");
    wr(wa(4'd6), 8'h80);
    wr(wa(4'd7), 8'h80);
    run_secs_ticks(TPS);
    rd(wa(4'd10), 8'h82, "R9 all masked fires");
    wr(wa(4'd10), 8'h81);
    wr(wa(4'd9), 8'h00);

    // R10 oscillator failure restores base time
    wr(wa(4'd11), 8'h25);
    set_time(8'h24, 8'h06, 8'h15, 8'h12, 8'h34, 8'h56);
    run_secs_ticks(2 * (TPS - 5) - 1);
    rd(wa(4'd0), 8'h57, "R10 advanced before fail");
    wr(wa(4'd10), 8'h03);
    repeat (FAILC + 16) @(posedge clk);
    rd(wa(4'd10), 8'h01, "R10 fail flag, run bit kept");
    chk_pin(osc_fail, 1'b1, "R10 osc_fail pin");
    rd(wa(4'd0), 8'h56, "R10 sec reverted");
    rd(wa(4'd1), 8'h34, "R10 min reverted");
    rd(wa(4'd11), 8'h25, "R10 cal kept");
    wr(wa(4'd10), 8'h82);
    rd(wa(4'd10), 8'h80, "R11 fail cleared by 0");
    chk_pin(osc_fail, 1'b0, "R11 osc_fail pin clear");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule